// File: doc/BRIEF.md
# Collision Jam and Retry Controller

This block oversees one half-duplex frame transmission attempt at a time. A collision level that arrives with no fixed relation to the transmit clock is first synchronized and then filtered: it must hold for three consecutive transmit clocks before it counts. Once a collision is accepted inside the slot time, the block tells the data path to stop sending frame data and selects a 32-bit all-zero jam in its place. If the collision arrives while the preamble and start-of-frame delimiter are still going out, the jam waits until they are complete.

At the end of each jam the block either asks an external backoff timer for a retry or, after the sixteenth collided attempt of the same frame, reports that the frame is dropped. An attempt that reaches the slot time with no accepted collision counts as a success. The block then reports how many retries the frame needed and clears its attempt count. The data path supplies the running count of bits sent and the preamble-complete flag, and it starts each attempt with a one-cycle strobe.

Top module: `coll_jam_ctrl`

## Requirements
- R1: A collision is accepted only when the synchronized collision level is high for three consecutive clocks. If the level is first sampled high at clock edge 1, `data_abort` rises at edge 5. A level held for one or two clocks has no effect.
- R2: A collision accepted while `pre_done` is low raises `data_abort` at once but holds `jam_sel` low. `jam_sel` rises on the first edge at which `pre_done` is sampled high.
- R3: A collision accepted while `pre_done` is high and `bits_sent` is below 512 raises `data_abort` and `jam_sel` on the same edge.
- R4: `jam_sel` stays high for exactly 32 consecutive clocks, and `jam_bit` is 0 throughout.
- R5: On the edge where `jam_sel` falls, `tx_keep` falls too. On the same edge a one-cycle `retry_req` pulse is issued, unless R6 applies. `tx_keep` is high from the edge after `attempt_start` until the attempt ends.
- R6: The sixteenth consecutive collided attempt ends with a one-cycle `give_up` pulse and no `retry_req`, and it clears the attempt count to 0.
- R7: In an attempt, if `bits_sent` is sampled at 512 or more before any collision is accepted, `attempt_ok` pulses for one cycle on the next edge. With that pulse, `retries_used` shows the number of collided attempts since the count was last cleared, and the count then clears.
- R8: `attempt_start` has no effect while an attempt is in progress. After the jam ends, `tx_keep` stays low.
- R9: While reset is asserted, every single-bit output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one bit time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| col_async | input | 1 | Collision level, not synchronous to clk |
| attempt_start | input | 1 | One-cycle strobe that starts an attempt |
| bits_sent | input | 11 | Bits sent so far in the current attempt |
| pre_done | input | 1 | Preamble and delimiter fully sent |
| tx_keep | output | 1 | Attempt in progress; transmit enable may stay on |
| data_abort | output | 1 | Frame data must stop |
| jam_sel | output | 1 | Jam replaces frame data |
| jam_bit | output | 1 | Serial jam bit |
| retry_req | output | 1 | Backoff request pulse |
| give_up | output | 1 | Excess-collision drop pulse |
| attempt_ok | output | 1 | Successful attempt pulse |
| retries_used | output | 4 | Retries needed, valid with attempt_ok |

## Verification
The bench counts clock edges from the `attempt_start` strobe. A collision first sampled at edge 2 must show `data_abort` at edge 6. The jam starts at edge 6, or on the edge after `pre_done` rises if that is later. The retry or give-up pulse and the fall of `tx_keep` are due 32 edges after the jam starts, and a success pulse is due one edge after `bits_sent` reaches the slot size. Every input is driven on a falling edge and every output is read on a later falling edge. Each reading is compared with the edge number computed for that case, so an early or late result fails in the same way as a wrong value.

// File: rtl/cjr_pkg.sv
package cjr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_HOLD = 2'd2,
    ST_JAM  = 2'd3
  } cjr_state_e;

  // Next value of the persistence run counter, saturating at lim-1.
  function automatic int unsigned persist_step(int unsigned run, logic lvl, int unsigned lim);
    if (!lvl) return 0;
    if (run + 1 >= lim) return lim - 1;
    return run + 1;
  endfunction

  // True once the attempt has passed the slot time.
  function automatic logic slot_done(int unsigned bits, int unsigned slot);
    return bits >= slot;
  endfunction

  // Attempt count after one more collided attempt; wraps to 0 at the cap.
  function automatic int unsigned attempt_step(int unsigned cnt, int unsigned cap);
    if (cnt + 1 >= cap) return 0;
    return cnt + 1;
  endfunction

endpackage

// File: rtl/cjr_col_filter.sv
module cjr_col_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int PERSIST     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic col_async,
  output logic col_sync,
  output logic col_hit
);
  import cjr_pkg::*;

  localparam int RUN_W = $clog2(PERSIST + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(PERSIST - 1);

  logic [SYNC_STAGES-1:0] chain_q;
  logic [RUN_W-1:0]       run_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= col_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-2:0], col_async};
      end
    end
  endgenerate

  assign col_sync = chain_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= RUN_W'(persist_step(32'(run_q), col_sync, PERSIST));
  end

  assign col_hit = col_sync && (run_q == RUN_LAST);

endmodule

// File: rtl/cjr_jam_shifter.sv
module cjr_jam_shifter #(
  parameter int                  JAM_BITS    = 32,
  parameter logic [JAM_BITS-1:0] JAM_PATTERN = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active,
  output logic bit_out,
  output logic last
);
  localparam int CNT_W = $clog2(JAM_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(JAM_BITS - 1);

  logic [JAM_BITS-1:0] sreg_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else if (load) begin
      sreg_q <= JAM_PATTERN;
      cnt_q  <= '0;
      act_q  <= 1'b1;
    end else if (act_q) begin
      sreg_q <= {sreg_q[JAM_BITS-2:0], 1'b0};
      cnt_q  <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) act_q <= 1'b0;
    end
  end

  assign active  = act_q;
  assign bit_out = sreg_q[JAM_BITS-1];
  assign last    = act_q && (cnt_q == CNT_LAST);

endmodule

// File: rtl/cjr_attempt_ctr.sv
module cjr_attempt_ctr #(
  parameter int MAX_ATTEMPTS = 16,
  parameter int CNT_W        = $clog2(MAX_ATTEMPTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  input  logic             clear,
  output logic [CNT_W-1:0] count,
  output logic             at_final
);
  import cjr_pkg::*;

  localparam logic [CNT_W-1:0] CNT_FINAL = CNT_W'(MAX_ATTEMPTS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (bump)  cnt_q <= CNT_W'(attempt_step(32'(cnt_q), MAX_ATTEMPTS));
  end

  assign count    = cnt_q;
  assign at_final = (cnt_q == CNT_FINAL);

endmodule

// File: rtl/coll_jam_ctrl.sv
module coll_jam_ctrl #(
  parameter int SLOT_BITS    = 512,
  parameter int BITS_W       = 11,
  parameter int SYNC_STAGES  = 2,
  parameter int PERSIST      = 3,
  parameter int JAM_BITS     = 32,
  parameter int MAX_ATTEMPTS = 16,
  localparam int RETRY_W     = $clog2(MAX_ATTEMPTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               col_async,
  input  logic               attempt_start,
  input  logic [BITS_W-1:0]  bits_sent,
  input  logic               pre_done,
  output logic               tx_keep,
  output logic               data_abort,
  output logic               jam_sel,
  output logic               jam_bit,
  output logic               retry_req,
  output logic               give_up,
  output logic               attempt_ok,
  output logic [RETRY_W-1:0] retries_used
);
  import cjr_pkg::*;

  // Named internal events, visible to the bound checker.
  logic               col_sync;
  logic               col_hit;
  logic               slot_reached;
  logic               jam_load;
  logic               jam_active;
  logic               jam_last;
  logic               shift_bit;
  logic               att_bump;
  logic               att_clear;
  logic               att_final;
  logic [RETRY_W-1:0] att_cnt;

  cjr_state_e st_q, st_d;

  cjr_col_filter #(.SYNC_STAGES(SYNC_STAGES), .PERSIST(PERSIST)) u_filter (
    .clk(clk), .rst_n(rst_n), .col_async(col_async),
    .col_sync(col_sync), .col_hit(col_hit)
  );

  cjr_jam_shifter #(.JAM_BITS(JAM_BITS), .JAM_PATTERN('0)) u_jam (
    .clk(clk), .rst_n(rst_n), .load(jam_load),
    .active(jam_active), .bit_out(shift_bit), .last(jam_last)
  );

  cjr_attempt_ctr #(.MAX_ATTEMPTS(MAX_ATTEMPTS), .CNT_W(RETRY_W)) u_att (
    .clk(clk), .rst_n(rst_n), .bump(att_bump), .clear(att_clear),
    .count(att_cnt), .at_final(att_final)
  );

  assign slot_reached = slot_done(32'(bits_sent), SLOT_BITS);

  always_comb begin
    st_d      = st_q;
    jam_load  = 1'b0;
    att_bump  = 1'b0;
    att_clear = 1'b0;
    unique case (st_q)
      ST_IDLE: if (attempt_start) st_d = ST_SEND;
      ST_SEND: begin
        if (slot_reached) begin
          st_d      = ST_IDLE;
          att_clear = 1'b1;
        end else if (col_hit) begin
          if (pre_done) begin
            st_d     = ST_JAM;
            jam_load = 1'b1;
          end else begin
            st_d = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (pre_done) begin
          st_d     = ST_JAM;
          jam_load = 1'b1;
        end
      end
      ST_JAM: begin
        if (jam_last) begin
          st_d     = ST_IDLE;
          att_bump = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  logic               retry_q, give_q, ok_q;
  logic [RETRY_W-1:0] used_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      retry_q <= 1'b0;
      give_q  <= 1'b0;
      ok_q    <= 1'b0;
      used_q  <= '0;
    end else begin
      st_q    <= st_d;
      retry_q <= att_bump && !att_final;
      give_q  <= att_bump && att_final;
      ok_q    <= att_clear;
      used_q  <= att_clear ? att_cnt : '0;
    end
  end

  assign tx_keep      = (st_q != ST_IDLE);
  assign data_abort   = (st_q == ST_HOLD) || (st_q == ST_JAM);
  assign jam_sel      = (st_q == ST_JAM);
  assign jam_bit      = jam_sel && shift_bit;
  assign retry_req    = retry_q;
  assign give_up      = give_q;
  assign attempt_ok   = ok_q;
  assign retries_used = used_q;

endmodule

// File: rtl/cjr_checker.sv
module cjr_checker #(
  parameter int JAM_BITS = 32,
  parameter int RETRY_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               col_sync,
  input logic               pre_done,
  input logic               jam_sel,
  input logic               jam_bit,
  input logic               jam_active,
  input logic               data_abort,
  input logic               retry_req,
  input logic               give_up,
  input logic               attempt_ok,
  input logic               tx_keep,
  input logic [RETRY_W-1:0] att_cnt
);
  logic [15:0] jam_run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       jam_run_q <= '0;
    else if (jam_sel) jam_run_q <= jam_run_q + 1'b1;
    else              jam_run_q <= '0;
  end

  // R1: abort only after three synchronized high samples
  assert_persist_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_abort) |-> ($past(col_sync, 1) && $past(col_sync, 2) && $past(col_sync, 3)));

  // R2: jam never starts before the preamble is complete
  assert_jam_after_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam_sel) |-> $past(pre_done));

  // R3: jam implies frame data is stopped
  assert_jam_aborts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    jam_sel |-> (data_abort && jam_active));

  // R4: jam bits are zero and the jam lasts exactly JAM_BITS cycles
  assert_jam_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    jam_sel |-> !jam_bit);

  assert_jam_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jam_sel) |-> (jam_run_q == 16'(JAM_BITS)));

  // R5: retry pulse is one cycle wide and comes with the fall of tx_keep
  assert_retry_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |=> !retry_req);

  assert_retry_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |-> (!tx_keep && $past(jam_sel)));

  // R6: give-up leaves the attempt count cleared
  assert_giveup_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    give_up |-> (att_cnt == '0));

  // R7: at most one outcome per cycle
  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({retry_req, give_up, attempt_ok}));

endmodule

bind coll_jam_ctrl cjr_checker #(.JAM_BITS(JAM_BITS), .RETRY_W(RETRY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .col_sync(col_sync), .pre_done(pre_done),
  .jam_sel(jam_sel), .jam_bit(jam_bit), .jam_active(jam_active),
  .data_abort(data_abort), .retry_req(retry_req), .give_up(give_up),
  .attempt_ok(attempt_ok), .tx_keep(tx_keep), .att_cnt(att_cnt)
);

// File: tb/sim_coll_jam_ctrl.sv
module sim_coll_jam_ctrl;
  localparam int SLOT = 512;
  localparam int JAMN = 32;
  localparam int CAP  = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        col_async = 1'b0;
  logic        attempt_start = 1'b0;
  logic [10:0] bits_sent = '0;
  logic        pre_done = 1'b0;
  logic        tx_keep, data_abort, jam_sel, jam_bit;
  logic        retry_req, give_up, attempt_ok;
  logic [3:0]  retries_used;

  always #2 clk = ~clk;

  coll_jam_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .col_async(col_async), .attempt_start(attempt_start),
    .bits_sent(bits_sent), .pre_done(pre_done), .tx_keep(tx_keep),
    .data_abort(data_abort), .jam_sel(jam_sel), .jam_bit(jam_bit),
    .retry_req(retry_req), .give_up(give_up), .attempt_ok(attempt_ok),
    .retries_used(retries_used)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int exp_cnt = 0;

  // per-attempt observations, edge index counted from the start strobe
  int first_abort, first_jam, jam_count, retry_at, give_at, ok_at, ok_val, keep_fall;
  bit jam_nonzero, keep_late;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic run_attempt(input int len, input int pre_at, input int bits0,
                             input int slot_at, input int poke_at);
    bit prev_keep;
    first_abort = 0; first_jam = 0; jam_count = 0; retry_at = 0; give_at = 0;
    ok_at = 0; ok_val = -1; keep_fall = 0; jam_nonzero = 0; keep_late = 1;
    @(negedge clk);
    attempt_start = 1'b1;
    bits_sent     = 11'(bits0);
    pre_done      = (pre_at == 0);
    col_async     = 1'b0;
    prev_keep     = 1'b0;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (data_abort && first_abort == 0) first_abort = i;
      if (jam_sel) begin
        if (first_jam == 0) first_jam = i;
        jam_count++;
        if (jam_bit) jam_nonzero = 1'b1;
      end
      if (retry_req) retry_at = i;
      if (give_up) give_at = i;
      if (attempt_ok) begin ok_at = i; ok_val = int'(retries_used); end
      if (prev_keep && !tx_keep) keep_fall = i;
      prev_keep = tx_keep;
      if (i == 58) keep_late = tx_keep;
      attempt_start = (i == poke_at);
      col_async     = (i <= len);
      if (pre_at != 0 && i >= pre_at) pre_done = 1'b1;
      if (slot_at != 0 && i >= slot_at) bits_sent = 11'(SLOT);
    end
    attempt_start = 1'b0;
    col_async     = 1'b0;
    pre_done      = 1'b0;
    bits_sent     = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic judge(input int len, input int pre_at, input int bits0,
                       input int slot_at, input int poke_at);
    bit collided;
    int ej, ee, eo;
    collided = (len >= 3) && (bits0 < SLOT);
    if (collided) begin
      ej = (pre_at == 0) ? 6 : ((pre_at + 1 > 6) ? pre_at + 1 : 6);
      ee = ej + JAMN;
      check(first_abort == 6, "R1 abort edge", first_abort, 6);
      if (pre_at > 5) check(first_jam == ej, "R2 jam waits for preamble", first_jam, ej);
      else            check(first_jam == ej, "R3 jam with abort", first_jam, ej);
      check(jam_count == JAMN, "R4 jam length", jam_count, JAMN);
      check(jam_nonzero == 0, "R4 jam bits zero", int'(jam_nonzero), 0);
      check(keep_fall == ee, "R5 tx_keep fall", keep_fall, ee);
      if (exp_cnt == CAP - 1) begin
        check(give_at == ee, "R6 give_up edge", give_at, ee);
        check(retry_at == 0, "R6 no retry on final", retry_at, 0);
        exp_cnt = 0;
      end else begin
        check(retry_at == ee, "R5 retry edge", retry_at, ee);
        check(give_at == 0, "R5 no give_up", give_at, 0);
        exp_cnt++;
      end
      if (poke_at != 0) check(keep_late == 0, "R8 start ignored", int'(keep_late), 0);
    end else begin
      eo = (bits0 >= SLOT) ? 2 : slot_at + 1;
      check(first_abort == 0, "R1 short or post-slot collision ignored", first_abort, 0);
      check(ok_at == eo, "R7 success edge", ok_at, eo);
      check(ok_val == exp_cnt, "R7 retries used", ok_val, exp_cnt);
      check(keep_fall == eo, "R7 tx_keep fall", keep_fall, eo);
      exp_cnt = 0;
    end
  endtask

  task automatic attempt(input int len, input int pre_at, input int bits0,
                         input int slot_at, input int poke_at);
    run_attempt(len, pre_at, bits0, slot_at, poke_at);
    judge(len, pre_at, bits0, slot_at, poke_at);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs low during reset
    check({tx_keep, data_abort, jam_sel, retry_req, give_up, attempt_ok} == 6'b0,
          "R9 reset outputs", int'({tx_keep, data_abort, jam_sel, retry_req, give_up, attempt_ok}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: persistence sweep, short pulses first
    for (int len = 1; len <= 5; len++) attempt(len, 0, 100, (len < 3) ? 30 : 0, 0);
    attempt(0, 0, 600, 0, 0);                 // R7: reports collisions so far
    // R2: preamble deferral at several release points
    attempt(4, 3, 100, 0, 0);
    attempt(4, 10, 100, 0, 0);
    attempt(5, 20, 100, 0, 0);
    // R3: just inside the slot
    attempt(4, 0, SLOT - 1, 0, 0);
    // R7: at the slot boundary a collision is not acted on
    attempt(4, 0, SLOT, 0, 0);
    // R8: start strobe during the jam
    attempt(4, 0, 100, 0, 20);
    attempt(0, 0, SLOT, 0, 0);
    // R6: sixteen collided attempts, then a clean success
    for (int k = 0; k < CAP; k++) attempt(3, 0, 200, 0, 0);
    attempt(0, 0, SLOT, 0, 0);
    // R7: k collisions then success, k swept
    for (int k = 0; k <= 4; k++) begin
      for (int j = 0; j < k; j++) attempt(4, 0, 300, 0, 0);
      attempt(0, 0, 100, 25, 0);
    end
    summary();
  end

endmodule